// File: doc/BRIEF.md
# NaN Precision Converter

This block moves a NaN between the half, single and double binary floating-point formats. It keeps the sign and as much of the payload as the destination format can hold. Any source format can be paired with any destination format. Internally every source is first turned into a neutral form: a sign bit plus a 64-bit payload whose most significant fraction bit sits at bit 63. That form is then packed into the destination. Widening therefore appends zeros below the payload, and narrowing keeps the top fraction bits.

A set top fraction bit marks a quiet NaN. When the source is a signaling NaN the block raises an invalid flag. It does not quieten the payload it carries across. If the carried payload truncates to zero, the destination's default NaN is produced instead. A default-NaN mode input forces the default NaN every time. A build parameter selects between a purely combinational path and a variant with one register stage and a valid bit. The default is the registered variant.

Driving a value that is not a NaN is outside the contract of the block.

Top module: `nan_fmt_xlate`

## Requirements
- R1: `invalid` is 1 exactly when the accepted source is a signaling NaN, meaning an all-ones exponent, a top fraction bit of 0 and a nonzero remainder of the fraction. Quiet NaNs give 0.
- R2: The sign bit of the result is the most significant bit of the source format (bit 15, 31 or 63).
- R3: When the result is not a default NaN, it has an all-ones exponent and a fraction taken from the source fraction aligned at its most significant bit. Missing low bits are zero and excess low bits are dropped.
- R4: If the fraction kept for the destination is all zero, the result is the destination's default NaN.
- R5: When `dnan_mode` is 1, the result is always the destination's default NaN. `invalid` still follows R1.
- R6: The default NaNs are 0xFE00 for half, 0xFFC00000 for single and 0xFFF8000000000000 for double.
- R7: Source bits above the source format's width are ignored. Result bits above the destination width are 0. Narrow values sit in the low bits of the 64-bit buses.
- R8: Format codes are 0 for half, 1 for single and 2 for double. Code 3 behaves as double.
- R9: In the registered variant, the outputs appear on the clock edge after the inputs, and `out_valid` equals `in_valid` delayed by one cycle. A synchronous active-high reset clears `out_valid`, `dst_word` and `invalid` to 0.
- R10: A signaling NaN whose payload survives is not quietened. Its top fraction bit stays 0 in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word is present |
| src_word | input | 64 | Source NaN, low-aligned |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| dnan_mode | input | 1 | Force the default NaN |
| out_valid | output | 1 | Result is present |
| dst_word | output | 64 | Converted NaN, low-aligned, zero above the format width |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The checker assumes that every accepted source word is a genuine NaN in its declared format. Under that assumption each result must itself be a NaN, meaning an all-ones exponent and a nonzero fraction. To stay inside this contract, the sweep builds every source from an all-ones exponent and a fraction that is never zero. The fraction cycles through a walking one, a walking one with the quiet bit set, an all-ones fraction and a pseudo-random nonzero pattern. Narrow source formats have filler bits above their width. The sweep covers every source and destination code, both signs and both default-NaN settings.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

    localparam int unsigned BUS_W   = 64;
    localparam int unsigned NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_WIDE   = 2'd3
    } nan_fmt_e;

    typedef struct packed {
        logic             sign;
        logic [BUS_W-1:0] payload;
    } neutral_nan_t;

    function automatic int unsigned fmt_index(nan_fmt_e f);
        case (f)
            FMT_HALF:   return 0;
            FMT_SINGLE: return 1;
            default:    return 2;
        endcase
    endfunction

    function automatic int unsigned frac_bits(int unsigned idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int unsigned exp_bits(int unsigned idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] canon_nan(int unsigned idx);
        case (idx)
            0:       return 64'h0000_0000_0000_FE00;
            1:       return 64'h0000_0000_FFC0_0000;
            default: return 64'hFFF8_0000_0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
    import nanconv_pkg::*;
(
    input  logic [BUS_W-1:0] src_word,
    input  nan_fmt_e         src_fmt,
    output neutral_nan_t     nan_o,
    output logic             is_snan
);
    logic [NUM_FMT-1:0] snan_v;
    logic [NUM_FMT-1:0] sign_v;
    logic [BUS_W-1:0]   pay_v [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int unsigned FW = frac_bits(g);
        localparam int unsigned EW = exp_bits(g);
        localparam int unsigned SH = BUS_W - FW;
        logic exp_full;
        logic quiet_bit;
        logic rest_set;
        assign exp_full  = &src_word[FW+EW-1:FW];
        assign quiet_bit = src_word[FW-1];
        assign rest_set  = |src_word[FW-2:0];
        assign snan_v[g] = exp_full & ~quiet_bit & rest_set;
        assign sign_v[g] = src_word[FW+EW];
        assign pay_v[g]  = src_word << SH;
    end

    always_comb begin
        int unsigned sel;
        sel           = fmt_index(src_fmt);
        is_snan       = snan_v[sel];
        nan_o.sign    = sign_v[sel];
        nan_o.payload = pay_v[sel];
    end
endmodule

// File: rtl/nan_pack.sv
module nan_pack
    import nanconv_pkg::*;
(
    input  neutral_nan_t     nan_i,
    input  nan_fmt_e         dst_fmt,
    input  logic             dnan_mode,
    output logic [BUS_W-1:0] word_o
);
    logic [BUS_W-1:0] cand_v [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int unsigned FW = frac_bits(g);
        localparam int unsigned EW = exp_bits(g);
        logic [FW-1:0] kept;
        logic          empty;
        assign kept  = nan_i.payload[BUS_W-1 -: FW];
        assign empty = (kept == '0);
        assign cand_v[g] = (dnan_mode || empty) ? canon_nan(g)
                         : BUS_W'({nan_i.sign, {EW{1'b1}}, kept});
    end

    always_comb begin
        word_o = cand_v[fmt_index(dst_fmt)];
    end
endmodule

// File: rtl/nan_fmt_xlate.sv
module nan_fmt_xlate
    import nanconv_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] src_word,
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    input  logic        dnan_mode,
    output logic        out_valid,
    output logic [63:0] dst_word,
    output logic        invalid
);
    neutral_nan_t     mid;
    logic             snan_c;
    logic [BUS_W-1:0] word_c;

    nan_unpack u_unpack (
        .src_word (src_word),
        .src_fmt  (nan_fmt_e'(src_fmt)),
        .nan_o    (mid),
        .is_snan  (snan_c)
    );

    nan_pack u_pack (
        .nan_i     (mid),
        .dst_fmt   (nan_fmt_e'(dst_fmt)),
        .dnan_mode (dnan_mode),
        .word_o    (word_c)
    );

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                dst_word  <= '0;
                invalid   <= 1'b0;
            end else begin
                out_valid <= in_valid;
                dst_word  <= word_c;
                invalid   <= in_valid & snan_c;
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign dst_word  = word_c;
        assign invalid   = in_valid & snan_c;
    end
endmodule

// File: rtl/nan_fmt_xlate_chk.sv
module nan_fmt_xlate_chk
    import nanconv_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  dst_fmt,
    input logic        dnan_mode,
    input logic        out_valid,
    input logic [63:0] dst_word,
    input logic        invalid
);
    logic       r_valid;
    logic [1:0] r_dst;
    logic       r_dnan;
    logic       ap_valid;
    logic [1:0] ap_dst;
    logic       ap_dnan;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_dst   <= 2'd0;
            r_dnan  <= 1'b0;
        end else begin
            r_valid <= in_valid;
            r_dst   <= dst_fmt;
            r_dnan  <= dnan_mode;
        end
    end

    assign ap_valid = REGISTERED ? r_valid : in_valid;
    assign ap_dst   = REGISTERED ? r_dst   : dst_fmt;
    assign ap_dnan  = REGISTERED ? r_dnan  : dnan_mode;

    function automatic logic high_clear(logic [63:0] w, logic [1:0] f);
        int unsigned i;
        i = fmt_index(nan_fmt_e'(f));
        return (w >> (frac_bits(i) + exp_bits(i) + 1)) == 64'd0;
    endfunction

    function automatic logic looks_nan(logic [63:0] w, logic [1:0] f);
        int unsigned i;
        logic [63:0] em;
        logic [63:0] fm;
        i  = fmt_index(nan_fmt_e'(f));
        fm = (64'd1 << frac_bits(i)) - 64'd1;
        em = ((64'd1 << exp_bits(i)) - 64'd1) << frac_bits(i);
        return ((w & em) == em) && ((w & fm) != 64'd0);
    endfunction

    assert_valid_track_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid == ap_valid);

    assert_flag_qualified_R1: assert property (@(posedge clk) disable iff (rst)
        invalid |-> out_valid);

    assert_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> high_clear(dst_word, ap_dst));

    assert_result_is_nan_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> looks_nan(dst_word, ap_dst));

    assert_forced_default_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ap_dnan) |-> dst_word == canon_nan(fmt_index(nan_fmt_e'(ap_dst))));
endmodule

bind nan_fmt_xlate nan_fmt_xlate_chk #(.REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dst_fmt   (dst_fmt),
    .dnan_mode (dnan_mode),
    .out_valid (out_valid),
    .dst_word  (dst_word),
    .invalid   (invalid)
);

// File: tb/nan_fmt_xlate_tb.sv
module nan_fmt_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_word = '0;
    logic [1:0]  src_fmt = 2'd0;
    logic [1:0]  dst_fmt = 2'd0;
    logic        dnan_mode = 1'b0;
    logic        out_valid;
    logic [63:0] dst_word;
    logic        invalid;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nan_fmt_xlate u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
        .src_fmt(src_fmt), .dst_fmt(dst_fmt), .dnan_mode(dnan_mode),
        .out_valid(out_valid), .dst_word(dst_word), .invalid(invalid)
    );

    function automatic int fw_of(logic [1:0] f);
        return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
    endfunction
    function automatic int ew_of(logic [1:0] f);
        return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
    endfunction
    function automatic logic [63:0] dflt_of(logic [1:0] f);
        return (f == 2'd0) ? 64'hFE00 : (f == 2'd1) ? 64'hFFC0_0000
                                                    : 64'hFFF8_0000_0000_0000;
    endfunction

    // Build a NaN in format f from sign and fraction, with filler above its width.
    function automatic logic [63:0] build_src(logic [1:0] f, logic s, logic [63:0] fr);
        int w;
        logic [63:0] v;
        w = fw_of(f) + ew_of(f) + 1;
        v = (w == 64) ? 64'd0 : (64'hA5A5_5A5A_C3C3_3C3C & ~((64'd1 << w) - 64'd1));
        v = v | fr | (((64'd1 << ew_of(f)) - 64'd1) << fw_of(f));
        if (s) v[w-1] = 1'b1;
        return v;
    endfunction

    function automatic logic [63:0] model_word(logic [63:0] sw, logic [1:0] sf,
                                               logic [1:0] df, logic dn);
        int sfw, dfw;
        logic [63:0] fr;
        logic sg;
        sfw = fw_of(sf);
        dfw = fw_of(df);
        sg  = sw[sfw + ew_of(sf)];
        fr  = '0;
        for (int i = 0; i < dfw; i++)
            if (i < sfw) fr[dfw-1-i] = sw[sfw-1-i];
        if (dn || fr == 64'd0) return dflt_of(df);
        return fr | (((64'd1 << ew_of(df)) - 64'd1) << dfw)
                  | (64'(sg) << (dfw + ew_of(df)));
    endfunction

    function automatic logic model_inv(logic [63:0] sw, logic [1:0] sf);
        int sfw;
        sfw = fw_of(sf);
        return !sw[sfw-1] && ((sw & ((64'd1 << (sfw-1)) - 64'd1)) != 64'd0);
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic apply(string tag, logic [63:0] sw, logic [1:0] sf,
                         logic [1:0] df, logic dn);
        src_word = sw; src_fmt = sf; dst_fmt = df; dnan_mode = dn; in_valid = 1'b1;
        @(negedge clk);
        check64(tag, dst_word, model_word(sw, sf, df, dn));
        check64("R1", 64'(invalid), 64'(model_inv(sw, sf)));
        check64("R9", 64'(out_valid), 64'd1);
    endtask

    task automatic directed(string tag, logic [63:0] sw, logic [1:0] sf,
                            logic [1:0] df, logic dn, logic [63:0] ew, logic ei);
        src_word = sw; src_fmt = sf; dst_fmt = df; dnan_mode = dn; in_valid = 1'b1;
        @(negedge clk);
        check64(tag, dst_word, ew);
        check64(tag, 64'(invalid), 64'(ei));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check64("R9", dst_word, 64'd0);
        check64("R9", 64'(out_valid), 64'd0);
        check64("R9", 64'(invalid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check64("R9", 64'(out_valid), 64'd0);

        // R6: default NaN constants per destination
        directed("R6", 64'h7E00, 2'd0, 2'd0, 1'b1, 64'hFE00, 1'b0);
        directed("R6", 64'h7E00, 2'd0, 2'd1, 1'b1, 64'hFFC0_0000, 1'b0);
        directed("R6", 64'h7E00, 2'd0, 2'd2, 1'b1, 64'hFFF8_0000_0000_0000, 1'b0);
        // R5: forced default still flags a signaling source
        directed("R5", 64'h7C01, 2'd0, 2'd1, 1'b1, 64'hFFC0_0000, 1'b1);
        // R2: negative half quiet NaN widened to double
        directed("R2", 64'hFE00, 2'd0, 2'd2, 1'b0, 64'hFFF8_0000_0000_0000, 1'b0);
        // R7: filler above a half source is ignored
        directed("R7", 64'hFFFF_FFFF_A5A5_7E01, 2'd0, 2'd1, 1'b0, 64'h7FC0_2000, 1'b0);
        // R10: signaling NaN keeps quiet bit clear
        directed("R10", 64'h7FF0_0000_0000_0001, 2'd2, 2'd2, 1'b0, 64'h7FF0_0000_0000_0001, 1'b1);
        directed("R10", 64'h7C01, 2'd0, 2'd1, 1'b0, 64'h7F80_2000, 1'b1);
        // R4: payload lost in narrowing
        directed("R4", 64'h7FF0_0000_0000_0001, 2'd2, 2'd1, 1'b0, 64'hFFC0_0000, 1'b1);
        // R8: code 3 acts as double
        directed("R8", 64'hFFF8_0000_0000_0000, 2'd3, 2'd0, 1'b0, 64'hFE00, 1'b0);

        // R3 sweep over all format pairs, signs and modes
        for (int sf = 0; sf < 4; sf++)
            for (int df = 0; df < 4; df++)
                for (int dn = 0; dn < 2; dn++)
                    for (int sg = 0; sg < 2; sg++) begin
                        int fw;
                        fw = fw_of(2'(sf));
                        for (int k = 0; k < 2*fw + 2; k++) begin
                            logic [63:0] fr;
                            string tag;
                            if (k < fw)          fr = 64'd1 << k;
                            else if (k < 2*fw)   fr = (64'd1 << (k-fw)) | (64'd1 << (fw-1));
                            else if (k == 2*fw)  fr = (64'd1 << fw) - 64'd1;
                            else begin
                                lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
                                fr = {4{lfsr}} & ((64'd1 << fw) - 64'd1);
                                if (fr == 64'd0) fr = 64'd3;
                            end
                            begin
                                logic [63:0] sw;
                                sw = build_src(2'(sf), sg[0], fr);
                                if (dn != 0) tag = "R5";
                                else if (model_word(sw, 2'(sf), 2'(df), 1'b0) == dflt_of(2'(df))
                                         && fr[fw-1] == 1'b0) tag = "R4";
                                else if (sf == 3 || df == 3) tag = "R8";
                                else tag = "R3";
                                apply(tag, sw, 2'(sf), 2'(df), dn[0]);
                            end
                        end
                    end

        // R9: valid drops one cycle after in_valid
        in_valid = 1'b0;
        @(negedge clk);
        check64("R9", 64'(out_valid), 64'd0);
        check64("R1", 64'(invalid), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule